// File: doc/BRIEF.md
# Lane Sample-Rate Decimator

This block lowers the sample rate of one data lane by a programmable divisor. It works in one of two modes. In pick mode it forwards the first sample of every block of `divisor` samples. In averaging mode it forwards the mean of each block, computed as a sum followed by a right shift. Every incoming sample is formatted before it is decimated. Formatting applies an optional sign extension from a programmable bit position and then treats the value as signed or unsigned.

A lane carries either one 32-bit sample per word or two 16-bit samples per word. In the 16-bit case the earlier sample sits in the low half. Decimated 16-bit results are packed two to an output word in the same order. The configuration inputs are expected to stay constant while the block is out of reset. A new setting is applied by holding reset, changing the inputs, and releasing reset.

Top module: `lane_decimator`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `out_data` is 0.
- R2: In pick mode with 32-bit words, the first sample of each block of D consecutive valid words is output. `out_valid` rises in the cycle after the clock edge that accepts the block's last word.
- R3: In averaging mode with D a power of two, the output equals the floor of the block sum divided by D. The sum is taken as two's complement when `sgn_en`=1.
- R4: In averaging mode a divisor that is not a power of two is rounded down to a power of two. The block length is capped at 4096 samples.
- R5: A divisor of 0 behaves exactly as a divisor of 1.
- R6: With `half_mode`=1, bits [15:0] of each word are the earlier sample and bits [31:16] the later one. Two successive 16-bit results form one output word, with the earlier result in bits [15:0].
- R7: With `half_mode`=1 and averaging off, an odd divisor D greater than 1 acts as D-1.
- R8: With `sgn_en`=1 and `sign_pos` below the top bit of the sample width (31 or 15), every bit above `sign_pos` is replaced by bit `sign_pos`. With `sgn_en`=0, or a higher `sign_pos`, the sample is unchanged.
- R9: Unsigned averaging zero-extends the samples. A block of 4096 samples of all ones averages to all ones, with no overflow.
- R10: Cycles with `in_valid`=0 advance nothing. `out_valid` is high only in the cycle after an edge that accepted a valid word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word (one 32-bit or two 16-bit samples) |
| divisor | input | 16 | Decimation divisor in samples |
| avg_en | input | 1 | 1: average each block, 0: pick first sample |
| half_mode | input | 1 | 0: 32-bit samples, 1: 16-bit samples |
| sgn_en | input | 1 | 1: samples are signed |
| sign_pos | input | 5 | Bit whose value overwrites all higher bits |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Decimated output word |

## Verification
The vector table drives seeded pseudo-random words, a ramp, and all-ones words, with idle gaps inserted. Pick mode is run with divisors 1, 3, 0 and an odd divisor in 16-bit mode, which separates block-boundary errors from divisor-rounding errors. Averaging is run with signed and unsigned data and with rounded and capped divisors. An all-ones block of 4096 samples separates accumulator overflow (unsigned) from wrong signedness, since a signed result must come out as -1. Directed tests pin the output to the exact cycle after a block ends and show that idle cycles produce nothing.

// File: rtl/lane_dec_pkg.sv
package lane_dec_pkg;
  localparam int DEF_DATA_W   = 32;
  localparam int DEF_DIV_W    = 16;
  localparam int DEF_LOG2_MAX = 12;

  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_ONE  = 2'd1,
    RES_PAIR = 2'd2
  } res_kind_t;
endpackage

// File: rtl/lane_dec_plan.sv
module lane_dec_plan #(
  parameter int DIV_W    = 16,
  parameter int LOG2_MAX = 12,
  localparam int SH_W    = $clog2(LOG2_MAX + 1)
) (
  input  logic [DIV_W-1:0] divisor,
  input  logic             avg_en,
  input  logic             half_mode,
  output logic [DIV_W-1:0] blk_len,
  output logic [SH_W-1:0]  shift
);
  // index of the highest set bit (0 for zero input)
  function automatic int top_bit(input logic [DIV_W-1:0] x);
    int r;
    r = 0;
    for (int i = 0; i < DIV_W; i++) if (x[i]) r = i;
    return r;
  endfunction

  logic [DIV_W-1:0] d_eff;
  int               k;

  assign d_eff = (divisor == '0) ? DIV_W'(1) : divisor;

  always_comb begin
    k = top_bit(d_eff);
    if (k > LOG2_MAX) k = LOG2_MAX;
    shift = SH_W'(k);
    if (avg_en)
      blk_len = DIV_W'(1) << k;
    else if (half_mode && d_eff != DIV_W'(1))
      blk_len = d_eff & ~DIV_W'(1);
    else
      blk_len = d_eff;
  end
endmodule

// File: rtl/lane_dec_fmt.sv
module lane_dec_fmt #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 45,
  parameter int POS_W  = 5,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] in_data,
  input  logic              half_mode,
  input  logic              sgn_en,
  input  logic [POS_W-1:0]  sign_pos,
  output logic [ACC_W-1:0]  s_lo,
  output logic [ACC_W-1:0]  s_hi
);
  // overwrite bits (p, top] with bit p when signed
  function automatic logic [DATA_W-1:0] fill_above(input logic [DATA_W-1:0] v,
                                                   input int top, input int p,
                                                   input logic sg);
    logic [DATA_W-1:0] r;
    r = v;
    for (int b = 0; b < DATA_W; b++)
      if (sg && b > p && b <= top) r[b] = v[p];
    return r;
  endfunction

  // widen a value whose top bit is 'top' to the accumulator width
  function automatic logic [ACC_W-1:0] widen(input logic [DATA_W-1:0] v,
                                             input int top, input logic sg);
    logic [ACC_W-1:0] r;
    r = '0;
    for (int b = 0; b < DATA_W; b++)
      if (b <= top) r[b] = v[b];
    for (int b = 0; b < ACC_W; b++)
      if (b > top) r[b] = sg & v[top];
    return r;
  endfunction

  logic [ACC_W-1:0] half_val [2];
  logic [ACC_W-1:0] full_val;
  int               p;

  assign p = int'(sign_pos);

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [DATA_W-1:0] raw;
    assign raw = {{(DATA_W-HALF_W){1'b0}}, in_data[h*HALF_W +: HALF_W]};
    assign half_val[h] = widen(fill_above(raw, HALF_W-1, p, sgn_en), HALF_W-1, sgn_en);
  end

  assign full_val = widen(fill_above(in_data, DATA_W-1, p, sgn_en), DATA_W-1, sgn_en);
  assign s_lo = half_mode ? half_val[0] : full_val;
  assign s_hi = half_mode ? half_val[1] : '0;
endmodule

// File: rtl/lane_dec_accum.sv
module lane_dec_accum
  import lane_dec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 45,
  parameter int LEN_W  = 16,
  parameter int SH_W   = 4,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              half_mode,
  input  logic              avg_en,
  input  logic [LEN_W-1:0]  blk_len,
  input  logic [SH_W-1:0]   shift,
  input  logic [ACC_W-1:0]  s_lo,
  input  logic [ACC_W-1:0]  s_hi,
  output res_kind_t         res_kind,
  output logic [DATA_W-1:0] res0,
  output logic [DATA_W-1:0] res1
);
  logic [CNT_W-1:0] cnt, step, nxt_cnt;
  logic [ACC_W-1:0] acc, pick, word_sum, total, avg_val, pick_val, chosen;
  logic             first, last, pair;

  assign first    = (cnt == '0);
  assign step     = half_mode ? CNT_W'(2) : CNT_W'(1);
  assign nxt_cnt  = cnt + step;
  assign last     = nxt_cnt >= {1'b0, blk_len};
  assign pair     = half_mode && (blk_len == LEN_W'(1));
  assign word_sum = half_mode ? (s_lo + s_hi) : s_lo;
  assign total    = (first ? '0 : acc) + word_sum;
  assign avg_val  = ACC_W'($signed(total) >>> shift);
  assign pick_val = first ? s_lo : pick;
  assign chosen   = avg_en ? avg_val : pick_val;

  always_comb begin
    if (!in_valid)  res_kind = RES_NONE;
    else if (pair)  res_kind = RES_PAIR;
    else if (last)  res_kind = RES_ONE;
    else            res_kind = RES_NONE;
  end

  assign res0 = pair ? s_lo[DATA_W-1:0] : chosen[DATA_W-1:0];
  assign res1 = s_hi[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      acc  <= '0;
      pick <= '0;
    end else if (in_valid && !pair) begin
      if (first) pick <= s_lo;
      if (last) begin
        cnt <= '0;
      end else begin
        cnt <= nxt_cnt;
        acc <= total;
      end
    end
  end

  // R2: the position within a block never reaches the block length
  a_r2_cnt_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < {1'b0, blk_len});

  // R2: the picked sample is only replaced at the start of a block
  a_r2_pick_held: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt != '0) |=> $stable(pick));
endmodule

// File: rtl/lane_dec_pack.sv
module lane_dec_pack
  import lane_dec_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_mode,
  input  res_kind_t         res_kind,
  input  logic [DATA_W-1:0] res0,
  input  logic [DATA_W-1:0] res1,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic              held;
  logic [HALF_W-1:0] hold_half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= 1'b0;
      hold_half <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (res_kind == RES_PAIR) begin
        out_valid <= 1'b1;
        out_data  <= {res1[HALF_W-1:0], res0[HALF_W-1:0]};
      end else if (res_kind == RES_ONE) begin
        if (!half_mode) begin
          out_valid <= 1'b1;
          out_data  <= res0;
        end else if (!held) begin
          held      <= 1'b1;
          hold_half <= res0[HALF_W-1:0];
        end else begin
          held      <= 1'b0;
          out_valid <= 1'b1;
          out_data  <= {res0[HALF_W-1:0], hold_half};
        end
      end
    end
  end

  // R6: a half result is only ever parked in 16-bit mode
  a_r6_hold_only_half: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> half_mode);
endmodule

// File: rtl/lane_decimator.sv
module lane_decimator
  import lane_dec_pkg::*;
#(
  parameter int DATA_W   = DEF_DATA_W,
  parameter int DIV_W    = DEF_DIV_W,
  parameter int LOG2_MAX = DEF_LOG2_MAX,
  localparam int POS_W   = $clog2(DATA_W),
  localparam int ACC_W   = DATA_W + LOG2_MAX + 1,
  localparam int SH_W    = $clog2(LOG2_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              avg_en,
  input  logic              half_mode,
  input  logic              sgn_en,
  input  logic [POS_W-1:0]  sign_pos,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic [DIV_W-1:0]  blk_len;
  logic [SH_W-1:0]   shift;
  logic [ACC_W-1:0]  s_lo, s_hi;
  res_kind_t         res_kind;
  logic [DATA_W-1:0] res0, res1;

  lane_dec_plan #(.DIV_W(DIV_W), .LOG2_MAX(LOG2_MAX)) u_plan (
    .divisor(divisor), .avg_en(avg_en), .half_mode(half_mode),
    .blk_len(blk_len), .shift(shift)
  );

  lane_dec_fmt #(.DATA_W(DATA_W), .ACC_W(ACC_W), .POS_W(POS_W)) u_fmt (
    .in_data(in_data), .half_mode(half_mode), .sgn_en(sgn_en),
    .sign_pos(sign_pos), .s_lo(s_lo), .s_hi(s_hi)
  );

  lane_dec_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W), .LEN_W(DIV_W), .SH_W(SH_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .half_mode(half_mode),
    .avg_en(avg_en), .blk_len(blk_len), .shift(shift), .s_lo(s_lo), .s_hi(s_hi),
    .res_kind(res_kind), .res0(res0), .res1(res1)
  );

  lane_dec_pack #(.DATA_W(DATA_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .half_mode(half_mode), .res_kind(res_kind),
    .res0(res0), .res1(res1), .out_valid(out_valid), .out_data(out_data)
  );

  // R10: an output word only follows an accepted input word
  a_r10_out_after_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
endmodule

// File: tb/lane_decimator_bench.sv
module lane_decimator_bench;
  typedef struct packed {
    logic [15:0] div;
    logic        avg;
    logic        w16;
    logic        sgn;
    logic [4:0]  pos;
    logic [15:0] nw;
    logic [1:0]  kind;   // 0 pseudo-random, 1 all ones, 2 ramp
    logic [31:0] seed;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{16'd1,    1'b0, 1'b0, 1'b0, 5'd31, 16'd8,    2'd0, 32'h1234_5678}, // R2 passthrough
    '{16'd3,    1'b0, 1'b0, 1'b0, 5'd31, 16'd30,   2'd0, 32'hCAFE_0001}, // R2
    '{16'd4,    1'b1, 1'b0, 1'b1, 5'd31, 16'd32,   2'd0, 32'h0BAD_F00D}, // R3 signed
    '{16'd8,    1'b1, 1'b0, 1'b0, 5'd31, 16'd32,   2'd0, 32'h7777_1111}, // R3 R9 unsigned
    '{16'd6,    1'b1, 1'b0, 1'b1, 5'd31, 16'd24,   2'd0, 32'h5A5A_0F0F}, // R4
    '{16'd0,    1'b0, 1'b0, 1'b0, 5'd31, 16'd10,   2'd2, 32'h0000_0003}, // R5
    '{16'd1,    1'b0, 1'b1, 1'b0, 5'd31, 16'd8,    2'd0, 32'h2468_ACE0}, // R6
    '{16'd4,    1'b0, 1'b1, 1'b1, 5'd7,  16'd16,   2'd0, 32'h1357_9BDF}, // R6 R8
    '{16'd5,    1'b0, 1'b1, 1'b0, 5'd31, 16'd20,   2'd2, 32'h0101_0101}, // R7
    '{16'd2,    1'b1, 1'b1, 1'b1, 5'd15, 16'd16,   2'd0, 32'h3C3C_A5A5}, // R3 R6
    '{16'd1,    1'b0, 1'b0, 1'b1, 5'd11, 16'd8,    2'd0, 32'h9999_4444}, // R8
    '{16'd4096, 1'b1, 1'b0, 1'b0, 5'd31, 16'd4096, 2'd1, 32'h0000_0000}, // R9
    '{16'd4096, 1'b1, 1'b0, 1'b1, 5'd31, 16'd4096, 2'd1, 32'h0000_0000}, // R3 signed -1
    '{16'd8192, 1'b1, 1'b0, 1'b1, 5'd31, 16'd4096, 2'd0, 32'hDEAD_BEEF}, // R4 cap
    '{16'd0,    1'b1, 1'b1, 1'b1, 5'd9,  16'd6,    2'd0, 32'hF0E1_D2C3}  // R5 R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic [15:0] divisor = 16'd1;
  logic        avg_en = 1'b0;
  logic        half_mode = 1'b0;
  logic        sgn_en = 1'b0;
  logic [4:0]  sign_pos = 5'd31;
  logic        out_valid;
  logic [31:0] out_data;

  int n_checks = 0;
  int n_fail = 0;
  logic collect = 1'b0;
  logic [31:0] got [$];
  logic [31:0] expv [$];

  always #5 clk = ~clk;

  lane_decimator u_lane_decimator (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .divisor(divisor), .avg_en(avg_en), .half_mode(half_mode), .sgn_en(sgn_en),
    .sign_pos(sign_pos), .out_valid(out_valid), .out_data(out_data)
  );

  always @(negedge clk)
    if (collect && rst_n && out_valid) got.push_back(out_data);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expd);
    n_checks++;
    if (act !== expd) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expd);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  function automatic logic [31:0] gen(input logic [1:0] kind, input logic [31:0] seed, input int i);
    logic [31:0] x;
    case (kind)
      2'd1:    x = 32'hFFFF_FFFF;
      2'd2:    x = seed + 32'(i) * 32'h0003_0007;
      default: begin
        x = seed ^ (32'(i + 1) * 32'h9E37_79B1);
        x = x ^ (x >> 13) ^ (x << 7);
      end
    endcase
    return x;
  endfunction

  // bench-side formatting: mask-based, then value as a signed integer
  function automatic longint fmtv(input logic [31:0] raw, input int w,
                                  input logic sg, input int pos);
    longint v, keep, full;
    v = longint'(raw);
    full = (longint'(1) << w) - 1;
    v = v & full;
    if (sg && pos < w - 1) begin
      keep = (longint'(1) << (pos + 1)) - 1;
      if (v[pos]) v = v | (full & ~keep);
      else        v = v & keep;
    end
    if (sg && v[w-1]) v = v - (longint'(1) << w);
    return v;
  endfunction

  task automatic build_expect(input vec_t vc);
    longint smp [$];
    longint res [$];
    int d, len, k, w;
    longint sum;
    w = vc.w16 ? 16 : 32;
    d = (vc.div == 0) ? 1 : int'(vc.div);
    k = 0;
    if (vc.avg) begin
      while ((2 << k) <= d && k < 12) k++;
      len = 1 << k;
    end else if (vc.w16 && d > 1 && (d % 2) == 1) len = d - 1;
    else len = d;
    for (int i = 0; i < int'(vc.nw); i++) begin
      logic [31:0] x;
      x = gen(vc.kind, vc.seed, i);
      if (vc.w16) begin
        smp.push_back(fmtv({16'h0, x[15:0]}, 16, vc.sgn, int'(vc.pos)));
        smp.push_back(fmtv({16'h0, x[31:16]}, 16, vc.sgn, int'(vc.pos)));
      end else smp.push_back(fmtv(x, 32, vc.sgn, int'(vc.pos)));
    end
    for (int b = 0; (b + 1) * len <= smp.size(); b++) begin
      if (vc.avg) begin
        sum = 0;
        for (int j = 0; j < len; j++) sum += smp[b*len + j];
        res.push_back(sum >>> k);
      end else res.push_back(smp[b*len]);
    end
    expv.delete();
    if (!vc.w16) foreach (res[i]) expv.push_back(res[i][31:0]);
    else for (int i = 0; i + 1 < res.size(); i += 2)
      expv.push_back({res[i+1][15:0], res[i][15:0]});
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    // R1: reset state, during reset and just after release
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 valid in reset", {31'b0, out_valid}, 32'd0);
    check("R1 data in reset", out_data, 32'd0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {31'b0, out_valid}, 32'd0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      vec_t vc;
      vc = VECS[v];
      rst_n = 1'b0;
      divisor = vc.div; avg_en = vc.avg; half_mode = vc.w16;
      sgn_en = vc.sgn; sign_pos = vc.pos;
      apply_reset();
      got.delete();
      build_expect(vc);
      collect = 1'b1;
      for (int i = 0; i < int'(vc.nw); i++) begin
        in_valid = 1'b1;
        in_data = gen(vc.kind, vc.seed, i);
        @(posedge clk);
        #1;
        if (i % 3 == 2) begin  // R10: idle gap between words
          in_valid = 1'b0;
          in_data = ~in_data;
          @(posedge clk);
          #1;
        end
      end
      in_valid = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      collect = 1'b0;
      check($sformatf("R2-vector %0d output count", v), 32'(got.size()), 32'(expv.size()));
      for (int i = 0; i < expv.size() && i < got.size(); i++)
        check($sformatf("vector %0d word %0d (R3 R6 R8 R9)", v, i), got[i], expv[i]);
    end

    // R2 / R10 directed timing: divisor 3, 32-bit pick
    rst_n = 1'b0;
    divisor = 16'd3; avg_en = 1'b0; half_mode = 1'b0; sgn_en = 1'b0; sign_pos = 5'd31;
    apply_reset();
    in_valid = 1'b1; in_data = 32'hA1A1_0001;
    @(posedge clk); #1 in_data = 32'hB2B2_0002;
    @(negedge clk);
    check("R2 no output after word 1", {31'b0, out_valid}, 32'd0);
    @(posedge clk); #1 in_data = 32'hC3C3_0003;
    @(negedge clk);
    check("R2 no output after word 2", {31'b0, out_valid}, 32'd0);
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    check("R2 output cycle after block end", {31'b0, out_valid}, 32'd1);
    check("R2 first sample picked", out_data, 32'hA1A1_0001);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1 in_data = 32'h5555_0000 + 32'(i);
      @(negedge clk);
      check("R10 idle cycles give no output", {31'b0, out_valid}, 32'd0);
    end
    // R10: idle words did not advance the block; three more valid words give one output
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1 in_valid = 1'b1; in_data = 32'h7000_0000 + 32'(i);
    end
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    check("R10 block restarts on valid words only", {31'b0, out_valid}, 32'd1);
    check("R10 picked word of new block", out_data, 32'h7000_0000);

    finish_run();
  end
endmodule